// File: doc/BRIEF.md
# Streaming Sliding-Window Pixel Cluster Finder

This block groups fired pixels of one pixel detector module into clusters while the hits stream in. Each hit is a row/column coordinate, and the hits arrive with the column never decreasing. The block keeps a window of `WIN` columns of the full-height pixel matrix in local registers. A neighbourhood-growth engine works inside that window and collects every pixel that is connected to a seed pixel, counting diagonal contact as connection.

The window moves forward only when an incoming hit lies beyond its right edge. Before each step, the pixels in the oldest column are turned into clusters and emitted. The window jumps straight over empty stretches. A hit whose column is lower than the one before it marks a new event: the whole window is flushed, and only then is that hit accepted. Each hit is loaded once and each cluster is grown once, so the work grows with the number of hits and never loops over the data a second time.

Each output record carries the following fields:
- a seed coordinate;
- an absolute bounding box;
- a saturating pixel count.

Records leave through a valid/ready port. While a record is held, the window does not move and no hit is accepted.

Top module: `cf_cluster_finder`

## Requirements
- R1: After reset no record is valid, the window is empty, and the first hit is accepted at any column; a reset also discards any pixels still pending.
- R2: Pixels that touch horizontally, vertically or diagonally (8-connectivity) form one cluster.
- R3: Pixels separated by at least one empty row or column on every path form separate clusters.
- R4: Each record reports the smallest and largest row and column of its pixels as absolute coordinates, in the same units as `in_row` and `in_col`.
- R5: `out_count` is the number of distinct pixels in the cluster, as an unsigned number that saturates at 2^CNT_W-1 (15 by default); a repeated hit on the same pixel counts once.
- R6: The seed is the lowest-row pixel of the cluster's leftmost column, and the seed column equals the minimum column.
- R7: A hit whose column is lower than the previous accepted column ends the event: every pending pixel is emitted before that hit is taken, and pixels of the two events never merge.
- R8: Records leave in ascending order of leftmost column, and within one leftmost column in ascending seed row.
- R9: While `out_valid` is high and `out_ready` is low, the record stays unchanged and `in_ready` stays low.
- R10: A hit at or beyond `WIN` columns past the oldest window column closes the clusters that start in that oldest column. Those clusters are limited to the `WIN` columns then held, so a wider run of pixels is emitted as several clusters.
- R11: Pending pixels produce no record until a later hit forces the window forward or ends the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit present |
| in_ready | output | 1 | Hit accepted on this edge |
| in_row | input | ROW_W | Hit row |
| in_col | input | COL_W | Hit column |
| out_valid | output | 1 | Cluster record present |
| out_ready | input | 1 | Downstream takes the record |
| out_seed_row | output | ROW_W | Seed row |
| out_seed_col | output | COL_W | Seed column |
| out_min_row | output | ROW_W | Lowest row of the cluster |
| out_min_col | output | COL_W | Lowest column of the cluster |
| out_max_row | output | ROW_W | Highest row of the cluster |
| out_max_col | output | COL_W | Highest column of the cluster |
| out_count | output | CNT_W | Saturating pixel count |

## Verification
The assertions assume three things about the input side:
- the hit held on the input stays stable until it is accepted;
- columns do not wrap around the `COL_W` range inside one event;
- a run of decreasing columns is used only to mark the start of a new event.

The stimulus keeps within these limits. Each hit is held until `in_ready`, all columns stay far below the column range, and each event is closed by a single lower-column hit. The record checks rely only on the bounding box, seed and count that the requirements define. Ready is throttled on two cycles out of three, so every record sits stalled for a while.

// File: rtl/cf_pkg.sv
package cf_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_GROW = 2'd1,
      ST_EMIT = 2'd2
   } cf_state_e;

endpackage

// File: rtl/cf_dilate.sv
module cf_dilate #(
   parameter int ROWS = 16,
   parameter int WIN  = 4,
   localparam int N   = ROWS * WIN
) (
   input  logic [N-1:0] mask_i,
   input  logic [N-1:0] occ_i,
   output logic [N-1:0] grown_o
);

   function automatic logic touch(input logic [N-1:0] m, input int c, input int r);
      logic t;
      t = 1'b0;
      for (int dc = -1; dc <= 1; dc++) begin
         for (int dr = -1; dr <= 1; dr++) begin
            if ((c + dc >= 0) && (c + dc < WIN) && (r + dr >= 0) && (r + dr < ROWS))
               t = t | m[(c + dc) * ROWS + r + dr];
         end
      end
      return t;
   endfunction

   for (genvar c = 0; c < WIN; c++) begin : g_col
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign grown_o[c*ROWS+r] = occ_i[c*ROWS+r] & touch(mask_i, c, r);
      end
   end

endmodule

// File: rtl/cf_measure.sv
module cf_measure #(
   parameter int ROWS  = 16,
   parameter int WIN   = 4,
   parameter int CNT_W = 4,
   localparam int N      = ROWS * WIN,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int COFF_W = $clog2(WIN),
   localparam int CMAX   = (1 << CNT_W) - 1
) (
   input  logic [N-1:0]      mask_i,
   output logic [ROW_W-1:0]  min_row_o,
   output logic [ROW_W-1:0]  max_row_o,
   output logic [COFF_W-1:0] min_coff_o,
   output logic [COFF_W-1:0] max_coff_o,
   output logic [CNT_W-1:0]  count_o
);

   logic [ROWS-1:0] row_any;
   logic [WIN-1:0]  col_any;
   int              total;

   always_comb begin
      row_any = '0;
      col_any = '0;
      total   = 0;
      for (int c = 0; c < WIN; c++) begin
         for (int r = 0; r < ROWS; r++) begin
            row_any[r] = row_any[r] | mask_i[c*ROWS+r];
            col_any[c] = col_any[c] | mask_i[c*ROWS+r];
            total      = total + int'(mask_i[c*ROWS+r]);
         end
      end
   end

   always_comb begin
      min_row_o = '0;
      max_row_o = '0;
      for (int r = ROWS - 1; r >= 0; r--) if (row_any[r]) min_row_o = ROW_W'(r);
      for (int r = 0; r < ROWS; r++)      if (row_any[r]) max_row_o = ROW_W'(r);
      min_coff_o = '0;
      max_coff_o = '0;
      for (int c = WIN - 1; c >= 0; c--) if (col_any[c]) min_coff_o = COFF_W'(c);
      for (int c = 0; c < WIN; c++)      if (col_any[c]) max_coff_o = COFF_W'(c);
      count_o = (total > CMAX) ? CNT_W'(CMAX) : CNT_W'(total);
   end

endmodule

// File: rtl/cf_cluster_finder.sv
module cf_cluster_finder
   import cf_pkg::*;
#(
   parameter int ROWS  = 16,
   parameter int WIN   = 4,
   parameter int COL_W = 8,
   parameter int CNT_W = 4,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int N      = ROWS * WIN,
   localparam int COFF_W = $clog2(WIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [ROW_W-1:0] in_row,
   input  logic [COL_W-1:0] in_col,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_seed_row,
   output logic [COL_W-1:0] out_seed_col,
   output logic [ROW_W-1:0] out_min_row,
   output logic [COL_W-1:0] out_min_col,
   output logic [ROW_W-1:0] out_max_row,
   output logic [COL_W-1:0] out_max_col,
   output logic [CNT_W-1:0] out_count
);

   if (ROWS < 2) begin : g_bad_rows
      $error("cf_cluster_finder: ROWS must be at least 2");
   end
   if (WIN < 2) begin : g_bad_win
      $error("cf_cluster_finder: WIN must be at least 2");
   end
   if (COL_W <= COFF_W) begin : g_bad_colw
      $error("cf_cluster_finder: COL_W must exceed the window offset width");
   end
   if (CNT_W < 1) begin : g_bad_cntw
      $error("cf_cluster_finder: CNT_W must be at least 1");
   end

   cf_state_e        st_q;
   logic [N-1:0]     win_q, mask_q, grown, hit_vec, seed_vec;
   logic [COL_W-1:0] base_q, prev_q, off;
   logic             flush_q, win_empty, in_win, is_eoe, fits;
   logic [ROW_W-1:0] seed_r;
   int               hit_idx;

   logic [ROW_W-1:0]  m_min_row, m_max_row;
   logic [COFF_W-1:0] m_min_coff, m_max_coff;
   logic [CNT_W-1:0]  m_count;

   assign win_empty = ~|win_q;
   assign off       = in_col - base_q;
   assign in_win    = (in_col >= base_q) && (off < COL_W'(WIN));
   assign is_eoe    = in_col < prev_q;
   assign fits      = win_empty || (!flush_q && !is_eoe && in_win);
   assign in_ready  = (st_q == ST_RUN) && fits;
   assign out_valid = (st_q == ST_EMIT);

   always_comb begin
      hit_idx = win_empty ? int'(in_row) : int'(off[COFF_W-1:0]) * ROWS + int'(in_row);
      hit_vec = '0;
      if (hit_idx < N) hit_vec[hit_idx] = 1'b1;
   end

   always_comb begin
      seed_r = '0;
      for (int r = ROWS - 1; r >= 0; r--) if (win_q[r]) seed_r = ROW_W'(r);
      seed_vec = '0;
      seed_vec[seed_r] = 1'b1;
   end

   cf_dilate #(.ROWS(ROWS), .WIN(WIN)) u_dilate (
      .mask_i (mask_q),
      .occ_i  (win_q),
      .grown_o(grown)
   );

   cf_measure #(.ROWS(ROWS), .WIN(WIN), .CNT_W(CNT_W)) u_measure (
      .mask_i    (mask_q),
      .min_row_o (m_min_row),
      .max_row_o (m_max_row),
      .min_coff_o(m_min_coff),
      .max_coff_o(m_max_coff),
      .count_o   (m_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q         <= ST_RUN;
         win_q        <= '0;
         mask_q       <= '0;
         base_q       <= '0;
         prev_q       <= '0;
         flush_q      <= 1'b0;
         out_seed_row <= '0;
         out_seed_col <= '0;
         out_min_row  <= '0;
         out_min_col  <= '0;
         out_max_row  <= '0;
         out_max_col  <= '0;
         out_count    <= '0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (in_valid && fits) begin
                  win_q   <= win_q | hit_vec;
                  prev_q  <= in_col;
                  flush_q <= 1'b0;
                  if (win_empty) base_q <= in_col;
               end else if (in_valid) begin
                  flush_q <= flush_q | is_eoe;
                  if (|win_q[ROWS-1:0]) begin
                     mask_q       <= seed_vec;
                     out_seed_row <= seed_r;
                     out_seed_col <= base_q;
                     st_q         <= ST_GROW;
                  end else begin
                     win_q  <= win_q >> ROWS;
                     base_q <= base_q + 1'b1;
                  end
               end
            end
            ST_GROW: begin
               if (grown == mask_q) begin
                  win_q       <= win_q & ~mask_q;
                  out_min_row <= m_min_row;
                  out_max_row <= m_max_row;
                  out_min_col <= base_q + COL_W'(m_min_coff);
                  out_max_col <= base_q + COL_W'(m_max_coff);
                  out_count   <= m_count;
                  st_q        <= ST_EMIT;
               end else begin
                  mask_q <= grown;
               end
            end
            ST_EMIT: if (out_ready) st_q <= ST_RUN;
            default: st_q <= ST_RUN;
         endcase
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_seed_row) && $stable(out_seed_col)
         && $stable(out_min_row) && $stable(out_max_row) && $stable(out_min_col)
         && $stable(out_max_col) && $stable(out_count)));

   // R9
   no_take_while_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R4
   box_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_min_row <= out_max_row) && (out_min_col <= out_max_col));

   // R6
   seed_in_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_seed_col == out_min_col) && (out_seed_row >= out_min_row)
                    && (out_seed_row <= out_max_row));

   // R5
   count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count != '0));

   // R2
   mask_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GROW) |-> ((mask_q & ~win_q) == '0));

   // R2
   grow_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_GROW) && ($past(st_q) == ST_GROW)) |-> (($past(mask_q) & ~mask_q) == '0));

endmodule

// File: tb/tb_cf_cluster_finder.sv
module tb_cf_cluster_finder;

   localparam int NH = 33;
   localparam int NE = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [3:0] in_row = '0;
   logic [7:0] in_col = '0;
   logic       out_valid;
   logic       out_ready = 1'b1;
   logic [3:0] out_seed_row, out_min_row, out_max_row, out_count;
   logic [7:0] out_seed_col, out_min_col, out_max_col;

   always #5 clk = ~clk;

   cf_cluster_finder dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_row(in_row), .in_col(in_col), .out_valid(out_valid), .out_ready(out_ready),
      .out_seed_row(out_seed_row), .out_seed_col(out_seed_col),
      .out_min_row(out_min_row), .out_min_col(out_min_col),
      .out_max_row(out_max_row), .out_max_col(out_max_col), .out_count(out_count)
   );

   // hit = {row, col}
   localparam logic [11:0] HITS [NH] = '{
      {4'd2,8'd1}, {4'd5,8'd1}, {4'd3,8'd2},
      {4'd10,8'd4}, {4'd10,8'd5}, {4'd10,8'd6}, {4'd10,8'd7}, {4'd10,8'd8},
      {4'd0,8'd20}, {4'd1,8'd20}, {4'd2,8'd20}, {4'd3,8'd20},
      {4'd0,8'd21}, {4'd1,8'd21}, {4'd2,8'd21}, {4'd3,8'd21},
      {4'd0,8'd22}, {4'd1,8'd22}, {4'd2,8'd22}, {4'd3,8'd22},
      {4'd0,8'd23}, {4'd1,8'd23}, {4'd2,8'd23}, {4'd3,8'd23},
      {4'd7,8'd0}, {4'd7,8'd0}, {4'd8,8'd1}, {4'd15,8'd3},
      {4'd8,8'd1}, {4'd9,8'd1}, {4'd11,8'd1}, {4'd12,8'd2},
      {4'd0,8'd0}
   };

   // record = {seed_row, seed_col, min_row, min_col, max_row, max_col, count}
   localparam logic [39:0] EXPV [NE] = '{
      {4'd2,8'd1,4'd2,8'd1,4'd3,8'd2,4'd2},
      {4'd5,8'd1,4'd5,8'd1,4'd5,8'd1,4'd1},
      {4'd10,8'd4,4'd10,8'd4,4'd10,8'd7,4'd4},
      {4'd10,8'd8,4'd10,8'd8,4'd10,8'd8,4'd1},
      {4'd0,8'd20,4'd0,8'd20,4'd3,8'd23,4'd15},
      {4'd7,8'd0,4'd7,8'd0,4'd8,8'd1,4'd2},
      {4'd15,8'd3,4'd15,8'd3,4'd15,8'd3,4'd1},
      {4'd8,8'd1,4'd8,8'd1,4'd9,8'd1,4'd2},
      {4'd11,8'd1,4'd11,8'd1,4'd12,8'd2,4'd2},
      {4'd3,8'd5,4'd3,8'd5,4'd3,8'd5,4'd1}
   };

   string tags [NE];
   int    n_chk = 0, n_fail = 0, nrec = 0, cyc = 0, n_stall = 0;
   bit    bp_en = 1'b0, stalled = 1'b0, done = 1'b0;
   logic [39:0] last_rec = '0;

   task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_hit(input logic [11:0] h);
      @(negedge clk);
      in_valid = 1'b1;
      in_row   = h[11:8];
      in_col   = h[7:0];
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      logic [39:0] cur;
      cyc++;
      cur = {out_seed_row, out_seed_col, out_min_row, out_min_col, out_max_row, out_max_col, out_count};
      if (rst_n) begin
         if (stalled && out_valid && n_stall < 12) begin
            n_stall++;
            check(cur == last_rec, "R9 record held under stall", cur, last_rec);
            check(in_ready == 1'b0, "R9 no hit taken while record pending", 40'(in_ready), 40'd0);
         end
         out_ready = bp_en ? ((cyc % 3) == 0) : 1'b1;
         if (out_valid && out_ready) begin
            if (nrec < NE)
               check(cur == EXPV[nrec], tags[nrec], cur, EXPV[nrec]);
            else
               check(1'b0, "R11 unexpected extra record", cur, 40'd0);
            nrec++;
            stalled = 1'b0;
         end else begin
            stalled = out_valid;
         end
         last_rec = cur;
      end else begin
         stalled = 1'b0;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d records expected=%0d", nrec, NE);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tags[0] = "R2/R4/R6 diagonal pair";
      tags[1] = "R3/R8 second seed in same column";
      tags[2] = "R10 wide run first piece";
      tags[3] = "R10 wide run remainder after window jump";
      tags[4] = "R5 saturating count of 16-pixel block";
      tags[5] = "R5/R7 duplicate hit counted once, flushed at event end";
      tags[6] = "R4/R7 top-row pixel flushed";
      tags[7] = "R7/R8 new event not merged, first seed";
      tags[8] = "R2/R8 second seed of new event";
      tags[9] = "R1 reset discarded pending pixel";

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid low in reset", 40'(out_valid), 40'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R1 out_valid low after reset", 40'(out_valid), 40'd0);
      check(in_ready == 1'b1, "R1 empty window ready for any column", 40'(in_ready), 40'd1);

      // Table walk with throttled output ready
      bp_en = 1'b1;
      for (int i = 0; i < NH; i++) send_hit(HITS[i]);
      repeat (60) @(negedge clk);
      // R11: terminator pixel (0,0) is pending and yields nothing
      check(nrec == 9, "R11 pending pixel held, record count", 40'(nrec), 40'd9);
      check(out_valid == 1'b0, "R11 no record while idle", 40'(out_valid), 40'd0);

      // R1: reset discards pending (0,0)
      bp_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      send_hit({4'd3, 8'd5});
      send_hit({4'd0, 8'd4});
      repeat (40) @(negedge clk);
      check(nrec == NE, "R1/R7 records after reset", 40'(nrec), 40'(NE));
      check(n_stall > 0, "R9 stall cycles observed", 40'(n_stall), 40'd1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule